// File: doc/BRIEF.md
# Ring Discovery Flood Filter

During self-healing of a sequenced ring, every node floods discovery packets on all of its transmit ports. This block sits in one node and handles that flood. A pulse on `start` clears its state and queues this node's own seed packet. After that, each incoming discovery packet is judged in the cycle it is accepted. The packet is either dropped or rewritten and queued for retransmission on every transmit port.

Each packet carries an origin node ID, the ID of the last node that relayed it, a hop count and a wrap bit. The block keeps a table that holds, for each origin, the longest hop count seen so far. This table is what keeps the flood from growing without limit. When this node's own packet comes back around a longer path than before, the block records the port it arrived on as the preferred receive port. A per-port flag marks the ports on which a packet was seen crossing the ring's ID wrap point. The table can be read from outside through a separate read port, so that later logic can make the path decisions.

Top module: `roster_filter`

## Requirements
- R1: In the cycle after `start`, the output queue holds exactly one packet: origin = `my_id`, relay ID = `my_id`, hop count 0, wrap bit 0. It is offered with `tx_mask` all ones. Any packets queued before `start` are discarded.
- R2: `start` clears every table entry to 0, clears every `port_wrap` bit and clears `rx_sel_valid`. `in_ready` is low during the `start` cycle.
- R3: A forwarded packet keeps its origin. Its relay ID is replaced with `my_id`. Its hop count is the received count plus one, saturating at 255.
- R4: A packet whose origin equals `my_id` is never forwarded.
- R5: For a packet whose origin equals `my_id`, the updated count is compared with `table[my_id]`. If it is strictly greater, that entry becomes the updated count, `rx_sel` becomes the arrival port and `rx_sel_valid` goes high. Otherwise the table entry and `rx_sel` keep their values.
- R6: A foreign packet with `my_id` < relay ID whose wrap bit is 1 is discarded, and its table entry is not changed.
- R7: A foreign packet with `my_id` < relay ID whose wrap bit is 0 sets `port_wrap[in_port]`. If it is forwarded, it leaves with wrap bit 1.
- R8: A foreign packet that R6 does not discard is forwarded only if its updated count is strictly greater than `table[origin]`, and in that case the entry takes the updated count. Otherwise it is discarded and the entry is left unchanged.
- R9: The output queue holds `DEPTH` packets (default 4) in arrival order. `in_ready` is low while it is full, and an offered packet is then neither judged nor recorded. The head stays on the outputs until `out_ready` is high.
- R10: `tbl_rd_data` shows `table[tbl_rd_addr]` combinationally, and it reflects an update from the clock edge that accepted the packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| my_id | input | 8 | This node's ID, held static |
| start | input | 1 | Begin a discovery round: clear state and queue the seed packet |
| in_valid | input | 1 | Incoming packet present |
| in_ready | output | 1 | Incoming packet accepted this cycle if valid |
| in_port | input | 2 | Receive port the packet arrived on |
| in_origin | input | 8 | Origin node ID |
| in_ltx | input | 8 | ID of last relaying node |
| in_count | input | 8 | Hop count |
| in_wrap | input | 1 | Wrap bit |
| out_valid | output | 1 | Queue head present |
| out_ready | input | 1 | Queue head taken this cycle |
| out_origin | output | 8 | Head origin ID |
| out_ltx | output | 8 | Head relay ID |
| out_count | output | 8 | Head hop count |
| out_wrap | output | 1 | Head wrap bit |
| tx_mask | output | 4 | Transmit ports the head goes out on |
| rx_sel | output | 2 | Preferred receive port |
| rx_sel_valid | output | 1 | `rx_sel` has been chosen this round |
| port_wrap | output | 4 | Per-port wrap-seen flags |
| tbl_rd_addr | input | 8 | Table read address |
| tbl_rd_data | output | 8 | Table entry at that address |

## Verification
A packet offered before a clock edge is judged at that edge. Its rewritten form, and any updates to the table, `rx_sel` and `port_wrap`, can be seen right after that edge. So each directed task drives its inputs on a falling edge and checks all results on the next falling edge. The bench holds `out_ready` low, so that a forwarded or discarded packet shows up as `out_valid` at that same falling edge. It then pops the head with a one-cycle `out_ready` pulse and confirms that the queue is empty. The seed packet after `start` is due at the first falling edge after the `start` edge, and it is checked there.

// File: rtl/roster_pkg.sv
package roster_pkg;
  localparam int unsigned ID_W  = 8;
  localparam int unsigned CNT_W = 8;

  typedef struct packed {
    logic [ID_W-1:0]  origin;
    logic [ID_W-1:0]  ltx;
    logic [CNT_W-1:0] count;
    logic             wrap;
  } rpkt_t;
endpackage

// File: rtl/roster_rst_sync.sv
module roster_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/roster_maxtab.sv
module roster_maxtab #(
  parameter int unsigned ID_W  = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             we,
  input  logic [ID_W-1:0]  wa,
  input  logic [CNT_W-1:0] wd,
  input  logic [ID_W-1:0]  ra_a,
  output logic [CNT_W-1:0] rd_a,
  input  logic [ID_W-1:0]  ra_b,
  output logic [CNT_W-1:0] rd_b
);
  localparam int unsigned ENTRIES = 1 << ID_W;

  logic [CNT_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (clr) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else if (we) begin
      mem[wa] <= wd;
    end
  end

  assign rd_a = mem[ra_a];
  assign rd_b = mem[ra_b];
endmodule

// File: rtl/roster_decide.sv
module roster_decide
  import roster_pkg::*;
(
  input  logic             acc,
  input  logic [ID_W-1:0]  my_id,
  input  rpkt_t            pkt_in,
  input  logic [CNT_W-1:0] tbl_val,
  output rpkt_t            pkt_out,
  output logic             fwd,
  output logic             tbl_we,
  output logic             sel_we,
  output logic             wrap_set
);
  logic [CNT_W-1:0] cnt_inc;
  logic             is_own;
  logic             crossing;
  logic             drop_wrap;
  logic             beats;

  assign cnt_inc   = (&pkt_in.count) ? pkt_in.count : pkt_in.count + 1'b1;
  assign is_own    = (pkt_in.origin == my_id);
  assign crossing  = (my_id < pkt_in.ltx);
  assign drop_wrap = crossing && pkt_in.wrap;
  assign beats     = (cnt_inc > tbl_val);

  always_comb begin
    pkt_out       = pkt_in;
    pkt_out.ltx   = my_id;
    pkt_out.count = cnt_inc;
    fwd           = 1'b0;
    tbl_we        = 1'b0;
    sel_we        = 1'b0;
    wrap_set      = 1'b0;
    if (acc) begin
      if (is_own) begin
        if (beats) begin
          tbl_we = 1'b1;
          sel_we = 1'b1;
        end
      end else begin
        if (crossing && !pkt_in.wrap) begin
          pkt_out.wrap = 1'b1;
          wrap_set     = 1'b1;
        end
        if (!drop_wrap && beats) begin
          tbl_we = 1'b1;
          fwd    = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/roster_txq.sv
module roster_txq
  import roster_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       flush,
  input  logic                       push,
  input  rpkt_t                      din,
  input  logic                       pop,
  output rpkt_t                      dout,
  output logic                       nempty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LVL_W = $clog2(DEPTH+1);

  rpkt_t              mem [DEPTH];
  logic [PTR_W-1:0]   wr_q, wr_n, rd_q, rd_n, wr_base, rd_base;
  logic [LVL_W-1:0]   lvl_q, lvl_n, lvl_base;
  logic               do_pop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_base  = flush ? '0 : wr_q;
    rd_base  = flush ? '0 : rd_q;
    lvl_base = flush ? '0 : lvl_q;
    do_pop   = pop && !flush && (lvl_q != '0);
    wr_n     = push   ? bump(wr_base) : wr_base;
    rd_n     = do_pop ? bump(rd_base) : rd_base;
    lvl_n    = lvl_base + LVL_W'(push) - LVL_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      lvl_q <= lvl_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_base] <= din;
  end

  assign dout   = mem[rd_q];
  assign nempty = (lvl_q != '0);
  assign full   = (lvl_q == LVL_W'(DEPTH));
  assign level  = lvl_q;
endmodule

// File: rtl/roster_filter.sv
module roster_filter
  import roster_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DEPTH  = 4,
  localparam int unsigned PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id,
  input  logic              start,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PW-1:0]     in_port,
  input  logic [ID_W-1:0]   in_origin,
  input  logic [ID_W-1:0]   in_ltx,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_wrap,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ID_W-1:0]   out_origin,
  output logic [ID_W-1:0]   out_ltx,
  output logic [CNT_W-1:0]  out_count,
  output logic              out_wrap,
  output logic [NPORTS-1:0] tx_mask,
  output logic [PW-1:0]     rx_sel,
  output logic              rx_sel_valid,
  output logic [NPORTS-1:0] port_wrap,
  input  logic [ID_W-1:0]   tbl_rd_addr,
  output logic [CNT_W-1:0]  tbl_rd_data
);
  localparam int unsigned LVL_W = $clog2(DEPTH+1);

  logic             rst_s;
  logic             acc;
  logic             q_full;
  logic             q_nempty;
  logic [LVL_W-1:0] q_level;
  rpkt_t            pkt_in, dec_pkt, seed_pkt, q_din, q_head;
  logic [CNT_W-1:0] tbl_val;
  logic             dec_fwd, dec_tbl_we, dec_sel_we, dec_wrap_set;

  logic [PW-1:0]     sel_q, sel_n;
  logic              selv_q, selv_n;
  logic [NPORTS-1:0] wrap_q, wrap_n;

  roster_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  assign in_ready = !start && !q_full;
  assign acc      = in_valid && in_ready;

  assign pkt_in   = '{origin: in_origin, ltx: in_ltx, count: in_count, wrap: in_wrap};
  assign seed_pkt = '{origin: my_id, ltx: my_id, count: '0, wrap: 1'b0};

  roster_maxtab #(.ID_W(ID_W), .CNT_W(CNT_W)) u_tab (
    .clk(clk), .rst_n(rst_s), .clr(start),
    .we(dec_tbl_we), .wa(in_origin), .wd(dec_pkt.count),
    .ra_a(in_origin), .rd_a(tbl_val),
    .ra_b(tbl_rd_addr), .rd_b(tbl_rd_data)
  );

  roster_decide u_dec (
    .acc(acc), .my_id(my_id), .pkt_in(pkt_in), .tbl_val(tbl_val),
    .pkt_out(dec_pkt), .fwd(dec_fwd), .tbl_we(dec_tbl_we),
    .sel_we(dec_sel_we), .wrap_set(dec_wrap_set)
  );

  assign q_din = start ? seed_pkt : dec_pkt;

  roster_txq #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst_n(rst_s), .flush(start), .push(start || dec_fwd),
    .din(q_din), .pop(out_ready), .dout(q_head), .nempty(q_nempty),
    .full(q_full), .level(q_level)
  );

  // receive-port selection and per-port wrap flags: next state
  always_comb begin
    sel_n  = sel_q;
    selv_n = selv_q;
    if (start) begin
      selv_n = 1'b0;
    end else if (dec_sel_we) begin
      sel_n  = in_port;
      selv_n = 1'b1;
    end
  end

  for (genvar gi = 0; gi < NPORTS; gi++) begin : g_wrap
    assign wrap_n[gi] = start ? 1'b0 :
                        ((dec_wrap_set && in_port == PW'(gi)) ? 1'b1 : wrap_q[gi]);
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      sel_q  <= '0;
      selv_q <= 1'b0;
      wrap_q <= '0;
    end else begin
      sel_q  <= sel_n;
      selv_q <= selv_n;
      wrap_q <= wrap_n;
    end
  end

  assign out_valid    = q_nempty;
  assign out_origin   = q_head.origin;
  assign out_ltx      = q_head.ltx;
  assign out_count    = q_head.count;
  assign out_wrap     = q_head.wrap;
  assign tx_mask      = {NPORTS{q_nempty}};
  assign rx_sel       = sel_q;
  assign rx_sel_valid = selv_q;
  assign port_wrap    = wrap_q;
endmodule

// File: rtl/roster_filter_chk.sv
module roster_filter_chk
  import roster_pkg::*;
#(
  parameter int unsigned NPORTS = 4,
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_s,
  input logic [ID_W-1:0]   my_id,
  input logic              start,
  input logic              acc,
  input logic              dec_fwd,
  input logic [ID_W-1:0]   in_origin,
  input logic [ID_W-1:0]   in_ltx,
  input logic              in_wrap,
  input logic              out_valid,
  input logic [ID_W-1:0]   out_origin,
  input logic [ID_W-1:0]   out_ltx,
  input logic [CNT_W-1:0]  out_count,
  input logic              out_wrap,
  input logic [NPORTS-1:0] tx_mask,
  input logic [NPORTS-1:0] port_wrap,
  input logic              rx_sel_valid,
  input logic [LVL_W-1:0]  q_level
);
  assert_seed_R1: assert property (@(posedge clk) disable iff (!rst_s)
    start |=> (out_valid && out_origin == $past(my_id) && out_ltx == $past(my_id)
               && out_count == '0 && !out_wrap && &tx_mask && q_level == LVL_W'(1)));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_s)
    start |=> (port_wrap == '0 && !rx_sel_valid));

  assert_relay_id_R3: assert property (@(posedge clk) disable iff (!rst_s)
    (out_valid && $stable(my_id)) |-> out_ltx == my_id);

  assert_own_dropped_R4: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && in_origin == my_id) |-> !dec_fwd);

  assert_sel_source_R5: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(rx_sel_valid) |-> $past(acc && in_origin == my_id));

  assert_wrap_drop_R6: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && in_origin != my_id && my_id < in_ltx && in_wrap) |-> !dec_fwd);

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_s)
    q_level <= LVL_W'(DEPTH));
endmodule

bind roster_filter roster_filter_chk #(.NPORTS(NPORTS), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .my_id(my_id), .start(start), .acc(acc),
  .dec_fwd(dec_fwd), .in_origin(in_origin), .in_ltx(in_ltx), .in_wrap(in_wrap),
  .out_valid(out_valid), .out_origin(out_origin), .out_ltx(out_ltx),
  .out_count(out_count), .out_wrap(out_wrap), .tx_mask(tx_mask),
  .port_wrap(port_wrap), .rx_sel_valid(rx_sel_valid), .q_level(q_level)
);

// File: tb/sim_roster_filter.sv
`timescale 1ns/1ps
module sim_roster_filter;
  localparam logic [7:0] ME = 8'h10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] my_id;
  logic       start, in_valid, in_ready, in_wrap, out_valid, out_ready, out_wrap;
  logic [1:0] in_port, rx_sel;
  logic [7:0] in_origin, in_ltx, in_count, out_origin, out_ltx, out_count;
  logic [3:0] tx_mask, port_wrap;
  logic       rx_sel_valid;
  logic [7:0] tbl_rd_addr, tbl_rd_data;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  roster_filter u0 (.*);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic offer(input logic [1:0] p, input logic [7:0] o, input logic [7:0] l,
                       input logic [7:0] c, input logic w);
    @(negedge clk);
    in_port = p; in_origin = o; in_ltx = l; in_count = c; in_wrap = w; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic tbl(input logic [7:0] a, input logic [7:0] exp, input string tag);
    tbl_rd_addr = a;
    #0.5;
    chk(tbl_rd_data == exp, tag, tbl_rd_data, exp);
  endtask

  task automatic chk_head(input logic [7:0] o, input logic [7:0] c, input logic w, input string tag);
    chk(out_valid && out_origin == o && out_ltx == ME && out_count == c && out_wrap == w
        && tx_mask == 4'hF, tag, {out_valid, out_origin, out_ltx, out_count, out_wrap},
        {1'b1, o, ME, c, w});
  endtask

  task automatic t_reset;
    chk(!out_valid && in_ready && !rx_sel_valid && port_wrap == 4'h0, "R2 reset state",
        {out_valid, in_ready, rx_sel_valid, port_wrap}, 7'b0100000);
    tbl(ME, 8'h00, "R10 reset table");
  endtask

  task automatic t_start;
    @(negedge clk); start = 1'b1;
    #0.5 chk(!in_ready, "R2 in_ready low at start", in_ready, 0);
    @(negedge clk); start = 1'b0;
    chk_head(ME, 8'h00, 1'b0, "R1 seed packet");
    chk(out_origin == ME, "R1 seed origin", out_origin, ME);
    pop();
    chk(!out_valid, "R1 single seed", out_valid, 0);
  endtask

  task automatic t_own;
    offer(2'd2, ME, 8'h30, 8'd4, 1'b0);
    chk(!out_valid, "R4 own packet not forwarded", out_valid, 0);
    chk(rx_sel_valid && rx_sel == 2'd2, "R5 receive port chosen", {rx_sel_valid, rx_sel}, 3'b110);
    tbl(ME, 8'd5, "R5 own table entry");
    offer(2'd1, ME, 8'h30, 8'd2, 1'b0);
    chk(rx_sel == 2'd2, "R5 shorter path ignored", rx_sel, 2);
    tbl(ME, 8'd5, "R5 entry kept");
    offer(2'd3, ME, 8'h30, 8'd5, 1'b0);
    chk(rx_sel == 2'd3 && !out_valid, "R5 longer path taken", {out_valid, rx_sel}, 3);
    tbl(ME, 8'd6, "R5 entry raised");
  endtask

  task automatic t_pass;
    offer(2'd0, 8'h20, 8'h05, 8'd3, 1'b0);
    chk_head(8'h20, 8'd4, 1'b0, "R3 pass-along rewritten");
    tbl(8'h20, 8'd4, "R8 entry updated");
    pop();
    offer(2'd0, 8'h20, 8'h05, 8'd3, 1'b0);
    chk(!out_valid, "R8 equal count discarded", out_valid, 0);
    offer(2'd1, 8'h20, 8'h07, 8'd7, 1'b0);
    chk_head(8'h20, 8'd8, 1'b0, "R8 larger count forwarded");
    pop();
    offer(2'd0, 8'h22, 8'h00, 8'hFF, 1'b0);
    chk_head(8'h22, 8'hFF, 1'b0, "R3 count saturates");
    tbl(8'h22, 8'hFF, "R3 saturated entry");
    pop();
    chk(port_wrap == 4'h0, "R7 no wrap when id above relay", port_wrap, 0);
  endtask

  task automatic t_wrap;
    offer(2'd1, 8'h40, 8'h50, 8'd1, 1'b0);
    chk_head(8'h40, 8'd2, 1'b1, "R7 wrap bit set on forward");
    chk(port_wrap == 4'b0010, "R7 port wrap flag", port_wrap, 4'b0010);
    pop();
    offer(2'd3, 8'h41, 8'h60, 8'd9, 1'b1);
    chk(!out_valid, "R6 second wrap discarded", out_valid, 0);
    tbl(8'h41, 8'h00, "R6 entry untouched");
    chk(port_wrap == 4'b0010, "R6 port flags unchanged", port_wrap, 4'b0010);
  endtask

  task automatic t_full;
    for (int i = 0; i < 4; i++) offer(2'd0, 8'h60 + 8'(i), 8'h00, 8'd0, 1'b0);
    chk(!in_ready, "R9 in_ready low when full", in_ready, 0);
    offer(2'd0, 8'h64, 8'h00, 8'd0, 1'b0);
    tbl(8'h64, 8'h00, "R9 refused packet not recorded");
    chk(out_origin == 8'h60, "R9 head held", out_origin, 8'h60);
    for (int i = 0; i < 4; i++) begin
      chk_head(8'h60 + 8'(i), 8'd1, 1'b0, "R9 order kept");
      pop();
    end
    chk(!out_valid && in_ready, "R9 drained", {out_valid, in_ready}, 2'b01);
  endtask

  task automatic t_restart;
    offer(2'd0, 8'h70, 8'h00, 8'd0, 1'b0);
    offer(2'd0, 8'h71, 8'h00, 8'd0, 1'b0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(port_wrap == 4'h0 && !rx_sel_valid, "R2 flags cleared", {port_wrap, rx_sel_valid}, 0);
    tbl(8'h20, 8'h00, "R2 table cleared");
    tbl(ME, 8'h00, "R2 own entry cleared");
    chk_head(ME, 8'h00, 1'b0, "R1 seed after restart");
    pop();
    chk(!out_valid, "R1 old packets flushed", out_valid, 0);
  endtask

  initial begin
    rst_n = 1'b0; my_id = ME; start = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_port = '0; in_origin = '0; in_ltx = '0; in_count = '0; in_wrap = 1'b0;
    tbl_rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_start();
    t_own();
    t_pass();
    t_wrap();
    t_full();
    t_restart();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule